// File: doc/BRIEF.md
# Framed Serial Slave Port with Header Phase

This block is the serial side of a host port. An external master moves bytes in SPI mode 0: the serial clock idles low, the slave samples its data input on rising edges, and the slave changes its data output on falling edges. There is no chip select. Instead, a low-going frame pulse before each byte starts a new 8-bit transfer. Every 16-bit quantity travels as two such transfers, low byte first. Within a byte the most significant bit goes first.

A message opens with a 16-bit header. While the header is being shifted in, the slave returns filler bytes. Once the header is complete, the slave presents it to the parallel side and pulls a status line low. The status line stays low until the parallel side acknowledges the header. After that, the line goes high and payload is exchanged. Each pair of received bytes becomes one payload word with a one-cycle strobe. Each outgoing word is taken from the parallel side at the start of its low byte. A message-end input from the parallel side returns the port to the header phase.

The block runs on a system clock. Its serial inputs are assumed to be already synchronized into that clock domain, and edges are detected by comparing each input with its value one cycle earlier. Each serial clock half-period must span at least two system clock cycles. A 25 MHz serial clock therefore needs a system clock of at least 100 MHz.

Top module: `spi_hdr_slave`

## Requirements
- R1: After reset, `hdr_stat` is 1, `ser_out` is 0, and `hdr_valid`, `rx_valid` and `tx_pull` are 0.
- R2: `ser_out` is 0 whenever no byte transfer is in progress. This covers the time before the first frame pulse and the time after the eighth rising serial clock edge of a byte.
- R3: A falling edge of `frame_n` starts a transfer of exactly 8 bits, taken most significant bit first on rising `ser_clk` edges. `ser_out` changes only after a `ser_clk` edge or a frame edge. A new falling edge of `frame_n` in the middle of a byte discards the partial bits and starts over.
- R4: In the header phase, the first byte is header bits 7..0 and the second byte is bits 15..8. After the second byte, `hdr_word` carries the header and `hdr_valid` is high for exactly one cycle.
- R5: During the header and while waiting for acknowledge, every byte returned on `ser_out` is the filler value 0x00.
- R6: `hdr_stat` goes to 0 together with `hdr_valid`. It stays 0 until `hdr_ack` is seen, and it is 1 in the cycle after `hdr_ack` is sampled high.
- R7: Bytes received while `hdr_stat` is 0 produce no payload word.
- R8: In the payload phase, each pair of received bytes, low byte first, yields one `rx_word` with `rx_valid` high for one cycle.
- R9: In the payload phase, `tx_pull` pulses for one cycle when a low byte starts, and `tx_word` is latched at that moment. Bits 7..0 of the latched word are sent in that byte and bits 15..8 in the next byte. Later changes of `tx_word` do not affect the high byte.
- R10: A `msg_end` pulse sets `hdr_stat` to 1 in the next cycle and makes the next two bytes a header again, from any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the master, idle low (synchronized) |
| frame_n | input | 1 | Active-low frame pulse; its falling edge starts a byte |
| ser_in | input | 1 | Serial data from the master |
| ser_out | output | 1 | Serial data to the master, 0 when idle |
| hdr_stat | output | 1 | Header status: 0 = header taken, 1 = payload may follow |
| hdr_word | output | 16 | Last received header |
| hdr_valid | output | 1 | One-cycle strobe for a new header |
| hdr_ack | input | 1 | Parallel side accepts the header |
| rx_word | output | 16 | Last received payload word |
| rx_valid | output | 1 | One-cycle strobe for a new payload word |
| tx_word | input | 16 | Payload word to send next |
| tx_pull | output | 1 | One-cycle strobe: `tx_word` was latched |
| msg_end | input | 1 | Ends the message; return to the header phase |

## Verification
A wrong byte-half selector shows up on the very next transfer. Words come out byte-swapped, the header strobe fires a byte early, or `tx_pull` fires on a high byte. A bit counter that is off by one leaves `ser_out` driven after the eighth edge, or shifts the received data by one bit; both are visible within that same byte. A phase register stuck in the wait state keeps `hdr_stat` low one cycle after `hdr_ack`, and a phase that leaves the wait state too early emits a payload word while `hdr_stat` is still low.

// File: rtl/spi_hdr_pkg.sv
package spi_hdr_pkg;

  // Message phase of the slave port
  typedef enum logic [1:0] {
    PH_HEADER  = 2'd0,  // collecting the two header bytes
    PH_WAIT    = 2'd1,  // header taken, waiting for parallel acknowledge
    PH_PAYLOAD = 2'd2   // exchanging payload words
  } phase_e;

endpackage

// File: rtl/spi_edge_det.sv
// Registers a vector of already-synchronized inputs and flags rising and
// falling edges, one system clock wide each.
module spi_edge_det #(
  parameter int              N    = 2,
  parameter logic [N-1:0]    IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= din;
  end

  always_comb begin
    rise = din & ~prev_q;
    fall = ~din & prev_q;
  end

endmodule

// File: rtl/spi_byte_shift.sv
// One byte transfer: loads on start, samples on rise, shifts out on fall.
module spi_byte_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              smp,
  input  logic              shf,
  input  logic              sdi,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              sdo,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              busy
);

  localparam int              CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic              act_q,  act_d;
  logic [CNT_W-1:0]  cnt_q,  cnt_d;
  logic [BYTE_W-1:0] rsh_q,  rsh_d;
  logic [BYTE_W-1:0] tsh_q,  tsh_d;
  logic [BYTE_W-1:0] rxb_q,  rxb_d;
  logic              done_q, done_d;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    rsh_d  = rsh_q;
    tsh_d  = tsh_q;
    rxb_d  = rxb_q;
    done_d = 1'b0;
    if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
      tsh_d = tx_byte;
    end else if (act_q) begin
      if (smp) begin
        rsh_d = {rsh_q[BYTE_W-2:0], sdi};
        cnt_d = cnt_q + ONE;
        if (cnt_q == LAST) begin
          act_d  = 1'b0;
          done_d = 1'b1;
          rxb_d  = {rsh_q[BYTE_W-2:0], sdi};
        end
      end else if (shf) begin
        tsh_d = {tsh_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      rsh_q  <= '0;
      tsh_q  <= '0;
      rxb_q  <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      rsh_q  <= rsh_d;
      tsh_q  <= tsh_d;
      rxb_q  <= rxb_d;
      done_q <= done_d;
    end
  end

  assign sdo       = act_q & tsh_q[BYTE_W-1];
  assign rx_byte   = rxb_q;
  assign byte_done = done_q;
  assign busy      = act_q;

endmodule

// File: rtl/spi_msg_ctrl.sv
// Message sequencing: header, wait for acknowledge, payload words.
module spi_msg_ctrl
  import spi_hdr_pkg::*;
#(
  parameter int                BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FILL   = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  byte_done,
  input  logic [BYTE_W-1:0]     rx_byte,
  input  logic                  hdr_ack,
  input  logic                  msg_end,
  input  logic [2*BYTE_W-1:0]   tx_word,
  output logic [BYTE_W-1:0]     tx_byte,
  output logic                  tx_pull,
  output logic [2*BYTE_W-1:0]   hdr_word,
  output logic                  hdr_valid,
  output logic [2*BYTE_W-1:0]   rx_word,
  output logic                  rx_valid,
  output logic                  hdr_stat
);

  localparam int WORD_W = 2 * BYTE_W;

  phase_e            ph_q,   ph_d;
  logic              hi_q,   hi_d;
  logic [BYTE_W-1:0] lo_q,   lo_d;
  logic [WORD_W-1:0] txh_q,  txh_d;
  logic [WORD_W-1:0] hdw_q,  hdw_d;
  logic              hdv_q,  hdv_d;
  logic [WORD_W-1:0] rxw_q,  rxw_d;
  logic              rxv_q,  rxv_d;
  logic              stat_q, stat_d;
  logic              pull_q, pull_d;
  logic              take_lo;

  assign take_lo = start && (ph_q == PH_PAYLOAD) && !hi_q;

  always_comb begin
    if (ph_q == PH_PAYLOAD) tx_byte = hi_q ? txh_q[WORD_W-1:BYTE_W] : tx_word[BYTE_W-1:0];
    else                    tx_byte = FILL;
  end

  always_comb begin
    ph_d   = ph_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    txh_d  = txh_q;
    hdw_d  = hdw_q;
    rxw_d  = rxw_q;
    stat_d = stat_q;
    hdv_d  = 1'b0;
    rxv_d  = 1'b0;
    pull_d = 1'b0;
    if (msg_end) begin
      ph_d   = PH_HEADER;
      hi_d   = 1'b0;
      stat_d = 1'b1;
    end else begin
      if (take_lo) begin
        txh_d  = tx_word;
        pull_d = 1'b1;
      end
      case (ph_q)
        PH_HEADER: begin
          if (byte_done) begin
            if (!hi_q) begin
              lo_d = rx_byte;
              hi_d = 1'b1;
            end else begin
              hdw_d  = {rx_byte, lo_q};
              hdv_d  = 1'b1;
              hi_d   = 1'b0;
              ph_d   = PH_WAIT;
              stat_d = 1'b0;
            end
          end
        end
        PH_WAIT: begin
          if (hdr_ack) begin
            ph_d   = PH_PAYLOAD;
            hi_d   = 1'b0;
            stat_d = 1'b1;
          end
        end
        PH_PAYLOAD: begin
          if (byte_done) begin
            if (!hi_q) begin
              lo_d = rx_byte;
              hi_d = 1'b1;
            end else begin
              rxw_d = {rx_byte, lo_q};
              rxv_d = 1'b1;
              hi_d  = 1'b0;
            end
          end
        end
        default: begin
          ph_d   = PH_HEADER;
          hi_d   = 1'b0;
          stat_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_HEADER;
      hi_q   <= 1'b0;
      lo_q   <= '0;
      txh_q  <= '0;
      hdw_q  <= '0;
      hdv_q  <= 1'b0;
      rxw_q  <= '0;
      rxv_q  <= 1'b0;
      stat_q <= 1'b1;
      pull_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      txh_q  <= txh_d;
      hdw_q  <= hdw_d;
      hdv_q  <= hdv_d;
      rxw_q  <= rxw_d;
      rxv_q  <= rxv_d;
      stat_q <= stat_d;
      pull_q <= pull_d;
    end
  end

  assign tx_pull   = pull_q;
  assign hdr_word  = hdw_q;
  assign hdr_valid = hdv_q;
  assign rx_word   = rxw_q;
  assign rx_valid  = rxv_q;
  assign hdr_stat  = stat_q;

endmodule

// File: rtl/spi_hdr_slave.sv
module spi_hdr_slave #(
  parameter int                BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FILL   = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                frame_n,
  input  logic                ser_in,
  output logic                ser_out,
  output logic                hdr_stat,
  output logic [2*BYTE_W-1:0] hdr_word,
  output logic                hdr_valid,
  input  logic                hdr_ack,
  output logic [2*BYTE_W-1:0] rx_word,
  output logic                rx_valid,
  input  logic [2*BYTE_W-1:0] tx_word,
  output logic                tx_pull,
  input  logic                msg_end
);

  localparam int SCK = 0;
  localparam int FRM = 1;

  logic [1:0]        rise, fall;
  logic              sclk_rise, sclk_fall, frm_fall;
  logic              byte_done, busy;
  logic [BYTE_W-1:0] rx_byte, tx_byte;

  spi_edge_det #(.N(2), .IDLE(2'b10)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({frame_n, ser_clk}),
    .rise (rise),
    .fall (fall)
  );

  assign sclk_rise = rise[SCK];
  assign sclk_fall = fall[SCK];
  assign frm_fall  = fall[FRM];

  spi_byte_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (frm_fall),
    .smp      (sclk_rise),
    .shf      (sclk_fall),
    .sdi      (ser_in),
    .tx_byte  (tx_byte),
    .sdo      (ser_out),
    .rx_byte  (rx_byte),
    .byte_done(byte_done),
    .busy     (busy)
  );

  spi_msg_ctrl #(.BYTE_W(BYTE_W), .FILL(FILL)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (frm_fall),
    .byte_done(byte_done),
    .rx_byte  (rx_byte),
    .hdr_ack  (hdr_ack),
    .msg_end  (msg_end),
    .tx_word  (tx_word),
    .tx_byte  (tx_byte),
    .tx_pull  (tx_pull),
    .hdr_word (hdr_word),
    .hdr_valid(hdr_valid),
    .rx_word  (rx_word),
    .rx_valid (rx_valid),
    .hdr_stat (hdr_stat)
  );

endmodule

// File: rtl/spi_hdr_slave_chk.sv
module spi_hdr_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic ser_out,
  input logic hdr_stat,
  input logic hdr_ack,
  input logic msg_end,
  input logic hdr_valid,
  input logic rx_valid,
  input logic tx_pull,
  input logic busy,
  input logic sclk_rise,
  input logic sclk_fall,
  input logic frm_fall
);

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_out);

  a_r3_out_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_out != $past(ser_out)) |-> $past(sclk_rise || sclk_fall || frm_fall));

  a_r4_hdr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> !hdr_valid);

  a_r6_stat_low_with_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> !hdr_stat);

  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_stat && !hdr_ack && !msg_end) |=> !hdr_stat);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_stat && hdr_ack) |=> hdr_stat);

  a_r7_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_stat |-> !rx_valid);

  a_r8_rx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r9_pull_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pull |-> hdr_stat);

  a_r10_end_release: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end |=> hdr_stat);

endmodule

bind spi_hdr_slave spi_hdr_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_out  (ser_out),
  .hdr_stat (hdr_stat),
  .hdr_ack  (hdr_ack),
  .msg_end  (msg_end),
  .hdr_valid(hdr_valid),
  .rx_valid (rx_valid),
  .tx_pull  (tx_pull),
  .busy     (busy),
  .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall),
  .frm_fall (frm_fall)
);

// File: tb/tb_spi_hdr_slave.sv
`timescale 1ns/1ps
module tb_spi_hdr_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, frame_n, ser_in, ser_out;
  logic        hdr_stat, hdr_valid, hdr_ack, rx_valid, tx_pull, msg_end;
  logic [15:0] hdr_word, rx_word, tx_word;

  int vecs = 0;
  int bad  = 0;
  int pulls = 0;
  bit finished = 0;
  logic [15:0] hdr_q[$];
  logic [15:0] rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hdr_slave dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n),
    .ser_in(ser_in), .ser_out(ser_out), .hdr_stat(hdr_stat),
    .hdr_word(hdr_word), .hdr_valid(hdr_valid), .hdr_ack(hdr_ack),
    .rx_word(rx_word), .rx_valid(rx_valid), .tx_word(tx_word),
    .tx_pull(tx_pull), .msg_end(msg_end)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops expected words as strobes appear
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (hdr_valid) begin
        if (hdr_q.size() == 0) chk(1'b0, "R4 unexpected header", {16'h0, hdr_word}, 32'h0);
        else begin
          logic [15:0] e;
          e = hdr_q.pop_front();
          chk(hdr_word == e, "R4 header word", {16'h0, hdr_word}, {16'h0, e});
        end
      end
      if (rx_valid) begin
        if (rx_q.size() == 0) chk(1'b0, "R7/R8 unexpected payload", {16'h0, rx_word}, 32'h0);
        else begin
          logic [15:0] e;
          e = rx_q.pop_front();
          chk(rx_word == e, "R8 payload word", {16'h0, rx_word}, {16'h0, e});
        end
      end
      if (tx_pull) pulls++;
    end
  end

  task automatic frame_pulse();
    frame_n = 1'b0; wclk(HALF);
    frame_n = 1'b1; wclk(HALF);
  endtask

  // Driver: one full byte, compares the returned byte
  task automatic xfer(input logic [7:0] mo, input logic [7:0] exp_mi, input string req);
    logic [7:0] got;
    frame_pulse();
    for (int i = 7; i >= 0; i--) begin
      ser_in = mo[i];
      wclk(HALF);
      got[i] = ser_out;
      ser_clk = 1'b1;
      wclk(HALF);
      ser_clk = 1'b0;
    end
    wclk(3);
    chk(got == exp_mi, req, {24'h0, got}, {24'h0, exp_mi});
    chk(ser_out == 1'b0, "R2 idle output after byte", {31'h0, ser_out}, 32'h0);
  endtask

  task automatic partial(input int nbits);
    frame_pulse();
    for (int i = 0; i < nbits; i++) begin
      ser_in = 1'b1;
      wclk(HALF);
      ser_clk = 1'b1;
      wclk(HALF);
      ser_clk = 1'b0;
    end
    wclk(HALF);
  endtask

  task automatic summary();
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; frame_n = 1'b1; ser_in = 1'b0;
    hdr_ack = 1'b0; msg_end = 1'b0; tx_word = 16'h0;
    wclk(3);
    // R1 reset state
    chk(hdr_stat == 1'b1, "R1 hdr_stat", {31'h0, hdr_stat}, 32'h1);
    chk(ser_out == 1'b0, "R1 ser_out", {31'h0, ser_out}, 32'h0);
    chk({hdr_valid, rx_valid, tx_pull} == 3'b000, "R1 strobes", {29'h0, hdr_valid, rx_valid, tx_pull}, 32'h0);
    rst_n = 1'b1;
    wclk(3);
    chk(ser_out == 1'b0, "R2 idle before first frame", {31'h0, ser_out}, 32'h0);

    // R3 aborted byte then header 0xA55A, low byte first; R5 filler 0x00
    partial(3);
    xfer(8'h5A, 8'h00, "R3/R5 header low byte filler");
    hdr_q.push_back(16'hA55A);
    xfer(8'hA5, 8'h00, "R5 header high byte filler");
    chk(hdr_stat == 1'b0, "R6 status low after header", {31'h0, hdr_stat}, 32'h0);

    // R7 byte while waiting: ignored, filler returned
    xfer(8'h33, 8'h00, "R5/R7 byte during wait");
    chk(hdr_stat == 1'b0, "R6 status held low", {31'h0, hdr_stat}, 32'h0);
    chk(rx_q.size() == 0 && hdr_q.size() == 0, "R7 nothing pending", 32'h0, 32'h0);

    // R6 acknowledge releases status one cycle later
    hdr_ack = 1'b1;
    chk(hdr_stat == 1'b0, "R6 status before ack edge", {31'h0, hdr_stat}, 32'h0);
    wclk(1);
    hdr_ack = 1'b0;
    chk(hdr_stat == 1'b1, "R6 status one cycle after ack", {31'h0, hdr_stat}, 32'h1);

    // R8/R9 payload: first word
    tx_word = 16'hC3E1;
    xfer(8'h34, 8'hE1, "R9 tx low byte word1");
    tx_word = 16'hFFFF;  // must not disturb the latched high byte
    rx_q.push_back(16'h1234);
    xfer(8'h12, 8'hC3, "R9 tx high byte word1 latched");
    // second word
    tx_word = 16'h0F80;
    xfer(8'hEF, 8'h80, "R9 tx low byte word2");
    rx_q.push_back(16'hBEEF);
    xfer(8'hBE, 8'h0F, "R9 tx high byte word2");
    wclk(2);
    chk(pulls == 2, "R9 tx_pull count", pulls, 32'd2);

    // R10 end of message, new header
    msg_end = 1'b1; wclk(1); msg_end = 1'b0;
    chk(hdr_stat == 1'b1, "R10 status after end", {31'h0, hdr_stat}, 32'h1);
    tx_word = 16'hAAAA;
    xfer(8'h02, 8'h00, "R10 header again filler");
    hdr_q.push_back(16'h0102);
    xfer(8'h01, 8'h00, "R10 header high filler");
    chk(hdr_stat == 1'b0, "R6 status low second header", {31'h0, hdr_stat}, 32'h0);

    // R10 end during wait, then another header
    msg_end = 1'b1; wclk(1); msg_end = 1'b0;
    chk(hdr_stat == 1'b1, "R10 status after end in wait", {31'h0, hdr_stat}, 32'h1);
    xfer(8'h88, 8'h00, "R10 header low after end in wait");
    hdr_q.push_back(16'h7788);
    xfer(8'h77, 8'h00, "R10 header high after end in wait");
    chk(hdr_stat == 1'b0, "R10 header taken", {31'h0, hdr_stat}, 32'h0);
    wclk(4);
    chk(hdr_q.size() == 0, "R4 all headers seen", hdr_q.size(), 32'h0);
    chk(rx_q.size() == 0, "R8 all payload seen", rx_q.size(), 32'h0);
    chk(pulls == 2, "R9 no pulls outside payload", pulls, 32'd2);
    summary();
  end

endmodule